// File: doc/BRIEF.md
# Four-Lane Reduced-Precision Float Adder

This block adds or subtracts two 128-bit vectors of single-precision floating-point numbers, four independent 32-bit lanes at a time. It uses a simplified arithmetic model meant for media and graphics throughput rather than full standard compliance. Values too small to be normal are treated as zero on the way in and on the way out. Every result is truncated toward zero. A result too large to represent is clamped to the largest finite magnitude instead of raising a flag. The unit has no status outputs, no traps and no rounding control.

A caller presents both operands, an add/subtract select that applies to all four lanes, and a valid strobe. The sum or difference appears a fixed number of cycles later with its own valid strobe. A new operation may be issued every cycle.

Top module: `simd_fadd4`

## Requirements
- R1: Each 128-bit operand and the result hold four independent 32-bit lanes, with lane 0 in bits 31:0 and lane k in bits 32k+31:32k. Each lane uses the single-precision encoding: sign in bit 31, exponent in bits 30:23, fraction in bits 22:0. No lane's result depends on any other lane.
- R2: `out_valid` is high exactly three clock cycles after `in_valid` was sampled high, and the result of that operation is on `out_res` in the same cycle. Operations may be issued on consecutive cycles.
- R3: When `in_sub` is 0, every lane computes A+B. When it is 1, every lane computes A−B.
- R4: An input whose exponent field is 0 is treated as a zero of the same sign, whatever its fraction holds.
- R5: The result is the exact sum or difference truncated toward zero to a 24-bit significand. No rounding up ever happens, and bits discarded during alignment still reduce a difference.
- R6: A nonzero exact result whose normalized exponent field would be 0 or less is returned as a zero carrying the sign of the exact result. The output is never a denormal encoding.
- R7: A result whose normalized exponent field would be 255 or more is returned as the largest finite magnitude (exponent 0xFE, fraction all ones) with the sign of the exact result.
- R8: An input with exponent field 255 is an ordinary finite value of that exponent, with no infinity or NaN meaning. The output never has exponent field 255.
- R9: An exact zero result is +0, except when both effective operands are negative zeros (the second operand's sign taken after the subtract select), in which case it is −0.
- R10: While `rst_n` is low and until three cycles after a valid operation is accepted, `out_valid` is low. Operations presented during reset produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| in_sub | input | 1 | 1 selects A−B, 0 selects A+B, for all lanes |
| in_a | input | 128 | Operand A, four 32-bit lanes |
| in_b | input | 128 | Operand B, four 32-bit lanes |
| out_valid | output | 1 | Result valid |
| out_res | output | 128 | Result, four 32-bit lanes |

## Verification
The hardest case to reach is a subtraction where the smaller operand's low bits fall entirely past the guard positions during alignment. Only the sticky bit can then pull the truncated result below a power of two. Directed operands cover it, for example one minus a value 30 binades smaller, which must come out as the largest value below one. The underflow and overflow edges are reached with operands chosen one unit apart at the smallest normal exponent and at the top exponent. A long randomized stream, with exponents biased close to each other, is then compared against an exact wide-integer model of the same flushing, truncation and saturation rules.

// File: rtl/fadd_pkg.sv
package fadd_pkg;
  localparam int unsigned FP_W    = 32;
  localparam int unsigned EXP_W   = 8;
  localparam int unsigned FRAC_W  = 23;
  localparam int unsigned SIG_W   = FRAC_W + 1;
  localparam int unsigned GRS_W   = 3;
  localparam int unsigned ALN_W   = SIG_W + GRS_W;
  localparam int unsigned SUM_W   = ALN_W + 1;
  localparam int unsigned LZ_W    = $clog2(ALN_W + 1);
  localparam int unsigned EXP_MAX = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;

  // operands ordered by magnitude, ready for alignment
  typedef struct packed {
    logic             sgn;
    logic             zneg;
    logic             sub;
    logic [EXP_W-1:0] exp;
    logic [EXP_W-1:0] dif;
    logic [SIG_W-1:0] sig_big;
    logic [SIG_W-1:0] sig_sml;
  } ord_t;

  // raw significand sum with guard bits
  typedef struct packed {
    logic             sgn;
    logic             zneg;
    logic [EXP_W-1:0] exp;
    logic [SUM_W-1:0] sum;
  } raw_t;
endpackage

// File: rtl/fadd_lzc.sv
module fadd_lzc #(
  parameter  int unsigned W  = 27,
  localparam int unsigned OW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d,
  output logic [OW-1:0] cnt
);
  always_comb begin
    cnt = OW'(W);
    for (int i = 0; i < W; i++) begin
      if (d[i]) cnt = OW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fadd_lane.sv
module fadd_lane
  import fadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        stg_en,
  input  logic              res_vld,
  input  logic [FP_W-1:0]   op_a,
  input  logic [FP_W-1:0]   op_b,
  input  logic              op_sub,
  output logic [FP_W-1:0]   res
);
  localparam int unsigned MAG_W = EXP_W + FRAC_W;
  localparam logic signed [EXP_W+1:0] E_TOP = (EXP_W+2)'(EXP_MAX);

  // ---------------- stage 1: flush, order by magnitude ----------------
  fp_word_t ua, ub;
  logic     a_nz, b_nz, sb_eff, b_gt;
  logic [MAG_W-1:0] mag_a, mag_b;
  logic [SIG_W-1:0] sig_a, sig_b;
  ord_t     ord_d, ord_q;

  assign ua = op_a;
  assign ub = op_b;

  always_comb begin
    a_nz   = |ua.exp;
    b_nz   = |ub.exp;
    sb_eff = ub.sgn ^ op_sub;
    mag_a  = a_nz ? {ua.exp, ua.frac} : '0;
    mag_b  = b_nz ? {ub.exp, ub.frac} : '0;
    sig_a  = a_nz ? {1'b1, ua.frac} : '0;
    sig_b  = b_nz ? {1'b1, ub.frac} : '0;
    b_gt   = mag_b > mag_a;
    ord_d.sgn     = b_gt ? sb_eff : ua.sgn;
    ord_d.zneg    = ua.sgn & sb_eff;
    ord_d.sub     = ua.sgn ^ sb_eff;
    ord_d.exp     = b_gt ? ub.exp : ua.exp;
    ord_d.dif     = b_gt ? (ub.exp - ua.exp) : (ua.exp - ub.exp);
    ord_d.sig_big = b_gt ? sig_b : sig_a;
    ord_d.sig_sml = b_gt ? sig_a : sig_b;
  end

  always_ff @(posedge clk) begin
    if (stg_en[0]) ord_q <= ord_d;
  end

  // ---------------- stage 2: align with sticky, add or subtract -------
  logic [ALN_W-1:0] sml_ext, sml_sh, lost_mask, aligned;
  logic             sticky;
  logic [SUM_W-1:0] big_ext;
  raw_t             raw_d, raw_q;

  always_comb begin
    sml_ext   = {ord_q.sig_sml, GRS_W'(0)};
    lost_mask = '0;
    if (ord_q.dif >= EXP_W'(ALN_W)) begin
      sml_sh = '0;
      sticky = |ord_q.sig_sml;
    end else begin
      sml_sh    = sml_ext >> ord_q.dif;
      lost_mask = (ALN_W'(1) << ord_q.dif) - ALN_W'(1);
      sticky    = |(sml_ext & lost_mask);
    end
    aligned   = {sml_sh[ALN_W-1:1], sml_sh[0] | sticky};
    big_ext   = {1'b0, ord_q.sig_big, GRS_W'(0)};
    raw_d.sgn  = ord_q.sgn;
    raw_d.zneg = ord_q.zneg;
    raw_d.exp  = ord_q.exp;
    raw_d.sum  = ord_q.sub ? (big_ext - {1'b0, aligned})
                           : (big_ext + {1'b0, aligned});
  end

  always_ff @(posedge clk) begin
    if (stg_en[1]) raw_q <= raw_d;
  end

  // ---------------- stage 3: normalize, truncate, clamp ---------------
  logic [LZ_W-1:0]           lz;
  logic [ALN_W-1:0]          norm;
  logic signed [EXP_W+1:0]   e_w;
  logic [FP_W-1:0]           res_d, res_q;
  logic [GRS_W-1:0]          grs_unused;

  fadd_lzc #(.W(ALN_W)) u_lzc (
    .d   (raw_q.sum[ALN_W-1:0]),
    .cnt (lz)
  );

  always_comb begin
    if (raw_q.sum[SUM_W-1]) begin
      norm = raw_q.sum[SUM_W-1:1];
      e_w  = $signed({2'b00, raw_q.exp}) + 1;
    end else begin
      norm = raw_q.sum[ALN_W-1:0] << lz;
      e_w  = $signed({2'b00, raw_q.exp}) - $signed({{(EXP_W+2-LZ_W){1'b0}}, lz});
    end
    grs_unused = norm[GRS_W-1:0];
    if (raw_q.sum == '0)
      res_d = {raw_q.zneg, (FP_W-1)'(0)};
    else if (e_w <= 0)
      res_d = {raw_q.sgn, (FP_W-1)'(0)};
    else if (e_w >= E_TOP)
      res_d = {raw_q.sgn, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
    else
      res_d = {raw_q.sgn, e_w[EXP_W-1:0], norm[ALN_W-2 -: FRAC_W]};
  end

  always_ff @(posedge clk) begin
    if (stg_en[2]) res_q <= res_d;
  end

  assign res = res_q;

  // R5
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_en[2] && raw_q.sum != '0) |-> norm[ALN_W-1]);

  // R6
  no_denorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && res[FP_W-2 -: EXP_W] == '0) |-> (res[FRAC_W-1:0] == '0));

  // R8
  no_top_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res[FP_W-2 -: EXP_W] != EXP_W'(EXP_MAX)));
endmodule

// File: rtl/simd_fadd4.sv
module simd_fadd4
  import fadd_pkg::*;
#(
  parameter  int unsigned LANES = 4,
  localparam int unsigned VEC_W = LANES * FP_W,
  localparam int unsigned PIPE  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sub,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_res
);
  logic [PIPE-1:0] vld_d, vld_q;
  logic [PIPE-1:0] stg_en;

  always_comb begin
    vld_d  = {vld_q[PIPE-2:0], in_valid};
    stg_en = {vld_q[PIPE-2:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q[PIPE-1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fadd_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .stg_en  (stg_en),
      .res_vld (vld_q[PIPE-1]),
      .op_a    (in_a[g*FP_W +: FP_W]),
      .op_b    (in_b[g*FP_W +: FP_W]),
      .op_sub  (in_sub),
      .res     (out_res[g*FP_W +: FP_W])
    );
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_valid) && !$past(in_valid, 2) && !$past(in_valid, 3) && !$past(rst_n, 3)) |-> !out_valid);
endmodule

// File: tb/simd_fadd4_test.sv
`timescale 1ns/1ps
module simd_fadd4_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_sub;
  logic [127:0] in_a, in_b;
  logic         out_valid;
  logic [127:0] out_res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  simd_fadd4 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_res(out_res)
  );

  // exact model: value = M * 2^-149, M a wide integer
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic sub);
    logic [287:0] ma, mb, m;
    logic sa, sb, s;
    int p, e;
    sa = a[31];
    sb = b[31] ^ sub;
    ma = (a[30:23] == 0) ? '0 : (288'({1'b1, a[22:0]}) << (int'(a[30:23]) - 1));
    mb = (b[30:23] == 0) ? '0 : (288'({1'b1, b[22:0]}) << (int'(b[30:23]) - 1));
    if (sa == sb) begin m = ma + mb; s = sa; end
    else if (ma >= mb) begin m = ma - mb; s = sa; end
    else begin m = mb - ma; s = sb; end
    if (m == '0) return {sa & sb, 31'b0};
    p = 0;
    for (int i = 0; i < 288; i++) if (m[i]) p = i;
    e = p - 22;
    if (e <= 0) return {s, 31'b0};
    if (e >= 255) return {s, 8'hFE, 23'h7FFFFF};
    m = m >> (p - 23);
    return {s, 8'(e), m[22:0]};
  endfunction

  // result monitor: one check per lane
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected out_valid actual=1 expected=0");
      end else begin
        logic [127:0] ev;
        string t;
        ev = exp_q.pop_front();
        t  = tag_q.pop_front();
        for (int k = 0; k < 4; k++) begin
          checks++;
          if (out_res[k*32 +: 32] !== ev[k*32 +: 32]) begin
            errors++;
            $display("FAIL %s lane %0d actual=%h expected=%h", t, k, out_res[k*32 +: 32], ev[k*32 +: 32]);
          end
        end
      end
    end
  end

  task automatic check_bit(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s out_valid actual=%b expected=%b", req, act, expv);
    end
  endtask

  task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic sub,
                       input logic [127:0] ev, input string tag);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    exp_q.push_back(ev);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic one(input logic [31:0] a, input logic [31:0] b, input logic sub,
                     input logic [31:0] e, input string tag);
    issue({4{a}}, {4{b}}, sub, {4{e}}, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b1; in_sub = 1'b0;
    in_a = {4{32'h3F800000}}; in_b = {4{32'h3F800000}};
    repeat (4) @(negedge clk);
    check_bit("R10 during reset", out_valid, 1'b0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_bit("R10 after reset", out_valid, 1'b0);
    end
  endtask

  task automatic t_latency();
    in_a = {4{32'h3F800000}}; in_b = {4{32'h40000000}}; in_sub = 1'b0; in_valid = 1'b1;
    exp_q.push_back({4{32'h40400000}}); tag_q.push_back("R2 latency");
    @(negedge clk); in_valid = 1'b0;
    check_bit("R2 cycle1", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R2 cycle2", out_valid, 1'b0);
    @(negedge clk);
    check_bit("R2 cycle3", out_valid, 1'b1);
    drain();
  endtask

  task automatic t_addsub();
    one(32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, "R3 3-1");
    one(32'h3FC00000, 32'hBF000000, 1'b0, 32'h3F800000, "R3 1.5+-0.5");
    one(32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, "R3 1--1");
    drain();
  endtask

  task automatic t_lanes();
    issue({32'h40400000, 32'h3F800000, 32'h7F7FFFFF, 32'h00000000},
          {32'h3F800000, 32'h3F800000, 32'h7F7FFFFF, 32'h00000000}, 1'b0,
          {32'h40800000, 32'h40000000, 32'h7F7FFFFF, 32'h00000000}, "R1 lanes add");
    issue({32'h40400000, 32'h3F800000, 32'h7F7FFFFF, 32'h00000000},
          {32'h3F800000, 32'h3F800000, 32'h7F7FFFFF, 32'h00000000}, 1'b1,
          {32'h40000000, 32'h00000000, 32'h00000000, 32'h00000000}, "R1 lanes sub");
    drain();
  endtask

  task automatic t_denorm_in();
    one(32'h007FFFFF, 32'h00800000, 1'b0, 32'h00800000, "R4 denorm+min");
    one(32'h807FFFFF, 32'h80000000, 1'b0, 32'h80000000, "R4 neg denorm sign");
    one(32'h3F800000, 32'h00400000, 1'b1, 32'h3F800000, "R4 1-denorm");
    drain();
  endtask

  task automatic t_trunc();
    one(32'h3F800000, 32'h34400000, 1'b0, 32'h3F800001, "R5 no round up");
    one(32'h3F800000, 32'h30800000, 1'b1, 32'h3F7FFFFF, "R5 sticky borrow");
    one(32'hBF800000, 32'h30800000, 1'b1, 32'hBF800000, "R5 toward zero neg");
    drain();
  endtask

  task automatic t_underflow();
    one(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, "R6 tiny pos");
    one(32'h00800000, 32'h00800001, 1'b1, 32'h80000000, "R6 tiny neg");
    one(32'h01000000, 32'h00FFFFFF, 1'b1, 32'h00000000, "R6 cross binade");
    one(32'h01000000, 32'h00800000, 1'b1, 32'h00800000, "R6 min normal kept");
    drain();
  endtask

  task automatic t_overflow();
    one(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F7FFFFF, "R7 pos clamp");
    one(32'hFF000000, 32'h7F000000, 1'b1, 32'hFF7FFFFF, "R7 neg clamp");
    drain();
  endtask

  task automatic t_top_exp();
    one(32'h7F800000, 32'h00000000, 1'b0, 32'h7F7FFFFF, "R8 top exp clamps");
    one(32'h7F800000, 32'h7F000000, 1'b1, 32'h7F000000, "R8 top exp finite");
    one(32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 32'h00000000, "R8 top exp cancel");
    drain();
  endtask

  task automatic t_zero_sign();
    one(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, "R9 cancel +0");
    one(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, "R9 -0+-0");
    one(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, "R9 -0-+0");
    one(32'h00000000, 32'h00000000, 1'b1, 32'h00000000, "R9 +0-+0");
    drain();
  endtask

  task automatic t_stream();
    for (int n = 0; n < 400; n++) begin
      logic [127:0] a, b, e;
      logic sub;
      sub = 1'($urandom);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] x, y;
        logic [7:0]  ex;
        x  = $urandom;
        ex = x[30:23] + 8'($urandom_range(0, 40)) - 8'd20;
        y  = {1'($urandom), ex, 23'($urandom)};
        if (n % 7 == 0) y = {1'($urandom), x[30:0]};
        a[k*32 +: 32] = x;
        b[k*32 +: 32] = y;
        e[k*32 +: 32] = model(x, y, sub);
      end
      issue(a, b, sub, e, "R5 stream");
      if (n % 5 == 0) @(negedge clk);
    end
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0; in_sub = 1'b0; in_a = '0; in_b = '0; rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_addsub();
    t_lanes();
    t_denorm_in();
    t_trunc();
    t_underflow();
    t_overflow();
    t_top_exp();
    t_zero_sign();
    t_stream();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule